// File: doc/BRIEF.md
# Transmit Event Interrupt Controller

This block gathers status pulses from the transmit side of an Ethernet MAC and merges them into one host interrupt line. Each of ten transmit events sets its own sticky status bit, whether or not that event is enabled. A separate enable bit for each event decides whether a set status bit drives the interrupt. Reading the status register returns the latched bits and clears them. If an event arrives in the same cycle as that clearing read, its bit stays set.

The block also holds a collision counter. Every collision strobe increments it, and a host read of the counter clears it. When the counter wraps it raises its own status event. Two events are qualified by side conditions. A carrier-loss strobe counts only while the attachment-unit port is selected. A buffer-freed strobe counts only while a transmit request is pending. The host reaches everything through a small register port: a two-bit address, write and read strobes, and a read data bus that is driven combinationally from the current state.

Top module: `tx_irq_ctrl`

## Requirements
- R1: After reset, the enable register, the status register, the collision counter and `irq` are all zero.
- R2: A one-cycle event strobe sets its status bit at the next clock edge, whether or not that bit is enabled. The status bit positions are: 0 transmit done, 1 collision, 2 late collision, 3 jabber, 4 signal-quality error, 5 carrier loss, 6 underrun, 7 sixteenth attempt, 8 buffer available, 9 counter overflow.
- R3: `irq` is high exactly when at least one status bit and its enable bit, at the same position, are both set.
- R4: A read at address 1 returns the status bits in positions [9:0] and clears them at that clock edge. An event strobe in the same cycle leaves its bit set.
- R5: A carrier-loss strobe sets status bit 5 only while `aui_sel` is high. Otherwise it has no effect.
- R6: A buffer-freed strobe sets status bit 8 only while `tx_pending` is high. Otherwise it has no effect.
- R7: The collision counter (address 2, bits [9:0]) increments once for each collision strobe. A read at address 2 returns the count and clears it. A collision in the same cycle as that read leaves the count at 1.
- R8: A collision at the count of 1023 wraps the counter to 0 and sets status bit 9.
- R9: The enable register at address 0 is written with bits [9:0] and reads them back. Writes to addresses 1, 2 and 3 are ignored. Address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_done | input | 1 | Frame sent successfully |
| ev_coll | input | 1 | Collision seen |
| ev_late | input | 1 | Late collision seen |
| ev_jab | input | 1 | Jabber condition |
| ev_sqe | input | 1 | Signal-quality error |
| ev_nocrs | input | 1 | No carrier after preamble |
| ev_under | input | 1 | Transmit data ran out mid-frame |
| ev_16try | input | 1 | Sixteenth attempt on one frame |
| buf_freed | input | 1 | Transmit buffer space freed |
| tx_pending | input | 1 | A transmit request is waiting |
| aui_sel | input | 1 | Attachment-unit port selected |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears on read) |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data |
| irq | output | 1 | Host interrupt |

## Verification
The stimulus table applies single, paired and all-at-once event patterns under different enable masks. This shows whether latching depends on the enable while the interrupt does not depend on anything else, and whether each event reaches its own bit position. The qualified events are each driven with their condition low and then high, which separates gating from plain latching. Directed cases hit an event and a clearing read in the same cycle, a collision together with a counter read, and the wrap from 1023 to 0. These cases show where a set or an increment could be lost.

// File: rtl/tx_irq_ctrl.sv
module tx_irq_ctrl #(
  parameter int CNT_W  = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_done,
  input  logic              ev_coll,
  input  logic              ev_late,
  input  logic              ev_jab,
  input  logic              ev_sqe,
  input  logic              ev_nocrs,
  input  logic              ev_under,
  input  logic              ev_16try,
  input  logic              buf_freed,
  input  logic              tx_pending,
  input  logic              aui_sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int NEV = 10;

  logic [NEV-1:0]   en_q, st_q, ev_vec;
  logic [CNT_W-1:0] cnt_q;
  logic             st_rd, cnt_rd, cnt_wrap;

  assign st_rd    = rd_en && addr == 2'd1;
  assign cnt_rd   = rd_en && addr == 2'd2;
  assign cnt_wrap = ev_coll && !cnt_rd && (&cnt_q);

  assign ev_vec = {cnt_wrap, buf_freed & tx_pending, ev_16try, ev_under,
                   ev_nocrs & aui_sel, ev_sqe, ev_jab, ev_late, ev_coll, ev_done};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      st_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_en && addr == 2'd0) en_q <= wdata[NEV-1:0];
      st_q <= (st_rd ? '0 : st_q) | ev_vec;
      if (cnt_rd)       cnt_q <= CNT_W'(ev_coll);
      else if (ev_coll) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign irq = |(st_q & en_q);

  always_comb begin
    rdata = '0;
    case (addr)
      2'd0:    rdata[NEV-1:0]   = en_q;
      2'd1:    rdata[NEV-1:0]   = st_q;
      2'd2:    rdata[CNT_W-1:0] = cnt_q;
      default: rdata = '0;
    endcase
  end
endmodule

module tx_irq_ctrl_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_done,
  input logic             ev_coll,
  input logic             ev_nocrs,
  input logic             aui_sel,
  input logic             wr_en,
  input logic             rd_en,
  input logic [1:0]       addr,
  input logic             irq,
  input logic [9:0]       en_q,
  input logic [9:0]       st_q,
  input logic [CNT_W-1:0] cnt_q
);
  // R3
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done && en_q[0] && !(wr_en && addr == 2'd0)) |=> irq);

  // R4
  keep_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done && rd_en && addr == 2'd1) |=> st_q[0]);

  // R5
  nocrs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_nocrs && !aui_sel && !st_q[5]) |=> !st_q[5]);

  // R7
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_coll && !(rd_en && addr == 2'd2) && !(&cnt_q)) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  // R8
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_coll && !(rd_en && addr == 2'd2) && (&cnt_q)) |=> (cnt_q == '0 && st_q[9]));
endmodule

bind tx_irq_ctrl tx_irq_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_done(ev_done), .ev_coll(ev_coll),
  .ev_nocrs(ev_nocrs), .aui_sel(aui_sel), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .irq(irq), .en_q(en_q), .st_q(st_q), .cnt_q(cnt_q)
);

// File: tb/tx_irq_ctrl_tb.sv
module tx_irq_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int NV = 9;
  // {stim[10:0] = {pend, aui, buf, 16try, under, nocrs, sqe, jab, late, coll, done}, en[9:0], exp_st[9:0], exp_irq}
  localparam logic [31:0] VEC [NV] = '{
    {11'h001, 10'h001, 10'h001, 1'b1},
    {11'h001, 10'h000, 10'h001, 1'b0},
    {11'h006, 10'h004, 10'h006, 1'b1},
    {11'h020, 10'h3FF, 10'h000, 1'b0},
    {11'h220, 10'h020, 10'h020, 1'b1},
    {11'h100, 10'h3FF, 10'h000, 1'b0},
    {11'h500, 10'h100, 10'h100, 1'b1},
    {11'h7FF, 10'h200, 10'h1FF, 1'b0},
    {11'h0D8, 10'h080, 10'h0D8, 1'b1}
  };

  logic clk = 0, rst_n = 0;
  logic ev_done = 0, ev_coll = 0, ev_late = 0, ev_jab = 0, ev_sqe = 0, ev_nocrs = 0;
  logic ev_under = 0, ev_16try = 0, buf_freed = 0, tx_pending = 0, aui_sel = 0;
  logic wr_en = 0, rd_en = 0;
  logic [1:0] addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic irq;
  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  tx_irq_ctrl u_dut (.*);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_stim(input logic [10:0] s);
    {tx_pending, aui_sel, buf_freed, ev_16try, ev_under, ev_nocrs,
     ev_sqe, ev_jab, ev_late, ev_coll, ev_done} = s;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic peek(input logic [1:0] a, input string req, input logic [15:0] exp);
    addr = a; #1; check(req, rdata, exp);
  endtask

  task automatic rd(input logic [1:0] a, input string req, input logic [15:0] exp);
    addr = a; rd_en = 1; #1; check(req, rdata, exp);
    @(negedge clk); rd_en = 0;
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk); wd++;
      if (wd > 100000) begin
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 irq", {15'b0, irq}, 16'h0);
    peek(2'd0, "R1 enable", 16'h0);
    peek(2'd1, "R1 status", 16'h0);
    peek(2'd2, "R1 count", 16'h0);

    for (int i = 0; i < NV; i++) begin
      wr(2'd0, {6'b0, VEC[i][20:11]});
      peek(2'd0, "R9 enable readback", {6'b0, VEC[i][20:11]});
      set_stim(VEC[i][31:21]);
      @(negedge clk);
      set_stim('0);
      // R2 R3 R5 R6
      check("R3 irq", {15'b0, irq}, {15'b0, VEC[i][0]});
      rd(2'd1, "R2 status", {6'b0, VEC[i][10:1]});
      peek(2'd1, "R4 cleared", 16'h0);
    end

    // R7 two collisions came from the table
    rd(2'd2, "R7 count", 16'd2);
    peek(2'd2, "R7 count cleared", 16'd0);

    // R9 writes to read-only addresses ignored
    wr(2'd1, 16'hFFFF);
    wr(2'd2, 16'hFFFF);
    wr(2'd3, 16'hFFFF);
    peek(2'd1, "R9 status unchanged", 16'h0);
    peek(2'd2, "R9 count unchanged", 16'h0);
    peek(2'd3, "R9 addr3 zero", 16'h0);

    // R4 event coincident with clearing read
    ev_done = 1; @(negedge clk); ev_done = 0;
    ev_16try = 1;
    rd(2'd1, "R4 read", 16'h001);
    ev_16try = 0;
    peek(2'd1, "R4 coincident set kept", 16'h080);
    ev_done = 1;
    rd(2'd1, "R4 read2", 16'h080);
    ev_done = 0;
    peek(2'd1, "R4 same bit kept", 16'h001);
    rd(2'd1, "R4 drain", 16'h001);

    // R7 collision with counter read
    ev_coll = 1; @(negedge clk);
    rd(2'd2, "R7 read with coll", 16'd1);
    ev_coll = 0;
    peek(2'd2, "R7 coincident count", 16'd1);
    rd(2'd2, "R7 drain", 16'd1);
    rd(2'd1, "R7 status drain", 16'h002);

    // R8 wrap
    wr(2'd0, 16'h0200);
    ev_coll = 1;
    repeat (1023) @(negedge clk);
    ev_coll = 0;
    peek(2'd2, "R8 count max", 16'd1023);
    check("R8 no irq yet", {15'b0, irq}, 16'h0);
    ev_coll = 1; @(negedge clk); ev_coll = 0;
    peek(2'd2, "R8 wrapped", 16'd0);
    check("R8 irq", {15'b0, irq}, 16'h1);
    rd(2'd1, "R8 status", 16'h202);
    check("R3 irq drops", {15'b0, irq}, 16'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule